// File: doc/BRIEF.md
# Tape Control-Pulse Mark Recorder

This block drives the record control-track line of a tape transport. Each pulse on the line lasts exactly one period of an external period tick, and its information sits in its high time. The block measures the length of the period that has just ended and sets the high time of the next pulse as a fraction of that length. The fraction depends on the pulse kind.

In the plain record mode the fraction comes from a software duty register. In the two index-writing modes the block records a framed word. A frame opens with a 0 pulse, carries 64 data pulses, and closes with another 0 pulse. Software supplies the data bits one at a time by writing a one-bit flag. A mode change to the abort code ends a frame at the next pulse boundary. In the address-mark mode, writing 0 to the flag places one long mark pulse on the tape, and every pulse boundary raises an interrupt.

The period tick, the mode code, the duty value and the flag writes are all synchronous to `clk`.

Top module: `ctl_mark_rec`

## Requirements
- R1: A pulse starts at each clock edge on which `period_tick` is 1. `rec_pulse` goes high in the next cycle and stays high for T cycles, where T is computed from L. L is the number of cycles from the previous tick edge to this one.
- R2: In mode code 0 (plain record), and whenever no frame or mark applies, T = floor(L × `duty_val` / 256).
- R3: With mode code 1 (index record), the first boundary after the block is armed starts a frame of 66 pulses: a 0 pulse, data pulses 1 to 64, then a 0 pulse. A 1 pulse has T = floor(L/4) and a 0 pulse has T = floor(L/2). Once a frame has started, it runs to its end whatever the mode, except for the abort code. The block is armed from reset, and again by any cycle with no frame in progress and a mode code other than 1 or 2.
- R4: A `flag_wr` strobe with `flag_val` stores a pending bit when the mode code is not 4. `bit_pending` reads 1 from the next cycle until a data-pulse boundary consumes the bit. A write in the same cycle as a consumption is kept as the next pending bit.
- R5: If no bit is pending at a data-pulse boundary, the previous data bit is repeated and `underrun` is set. Before the first data pulse, the previous bit counts as 0. `underrun` is sticky until the next frame start.
- R6: At the boundary after the closing 0 pulse, `irq` is 1 for one cycle, the frame ends, and that pulse uses the plain duty. A new frame does not begin until the block is re-armed.
- R7: Mode code 2 (rewrite) behaves exactly as mode code 1.
- R8: Mode code 3 (abort) seen at a boundary during a frame ends the frame. That pulse uses the plain duty, and no completion `irq` follows.
- R9: With mode code 4 (address mark), a `flag_wr` with `flag_val` = 0 makes the next pulse a mark with T = L − floor(L/4). A write of 1 in this mode has no effect.
- R10: With mode code 4 and no frame in progress, every boundary raises `irq` for one cycle.
- R11: After reset, `rec_pulse`, `irq`, `bit_pending` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_tick | input | 1 | One-cycle strobe marking a pulse boundary |
| mode_sel | input | 3 | 0 plain, 1 index, 2 rewrite, 3 abort, 4 address mark |
| duty_val | input | 8 | Plain-record duty, in 1/256 of the period |
| flag_wr | input | 1 | Write strobe for the data/mark flag |
| flag_val | input | 1 | Value written to the flag |
| rec_pulse | output | 1 | Record control pulse |
| irq | output | 1 | One-cycle interrupt request |
| bit_pending | output | 1 | A written bit is waiting to be recorded |
| underrun | output | 1 | A data bit had to be repeated in this frame |

## Verification
The hardest state to reach is deep inside a long frame. That is where the end-of-frame interrupt, a late abort and a bit underrun live, and each needs dozens of correctly timed flag writes before it. The bench writes each data bit during the pulse before the one that uses it. It measures the high time of every pulse in a 64-bit patterned word, and checks the interrupt only once all 66 pulses have been counted. For the underrun case it deliberately skips a write in rewrite mode. It then switches to abort and runs past the point where the frame would have completed, to show that no completion interrupt appears.

// File: rtl/ctl_mark_pkg.sv
// Package: shared mode codes and pulse kinds for the control-pulse mark recorder.
// Assumes mode codes 5..7 are unused and behave as plain record.
package ctl_mark_pkg;

    typedef enum logic [2:0] {
        MODE_PLAIN   = 3'd0,
        MODE_INDEX   = 3'd1,
        MODE_REWRITE = 3'd2,
        MODE_ABORT   = 3'd3,
        MODE_MARK    = 3'd4
    } rec_mode_e;

    typedef enum logic [1:0] {
        PK_PLAIN = 2'd0,
        PK_ONE   = 2'd1,
        PK_ZERO  = 2'd2,
        PK_MARK  = 2'd3
    } pulse_kind_e;

endpackage

// File: rtl/ctl_period_timer.sv
// Module: counts cycles within the current pulse, measures the length of
// each finished period and holds the high-time threshold for the pulse in
// progress. Assumes period_tick is a one-cycle strobe; the count saturates
// if ticks stop.
module ctl_period_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic [CNT_W-1:0] thresh_next,
    output logic [CNT_W-1:0] len_now,
    output logic             pulse_hi
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] thresh_q;

    // Length of the period ending at this edge, if this edge is a boundary.
    assign len_now = pos_q + CNT_W'(1);

    // Position counter: restart at a boundary, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (boundary) begin
            pos_q <= '0;
        end else if (pos_q != '1) begin
            pos_q <= pos_q + CNT_W'(1);
        end
    end

    // Threshold register: load the high time of the new pulse at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= '0;
        end else if (boundary) begin
            thresh_q <= thresh_next;
        end
    end

    // Output is high while the position is below the threshold.
    assign pulse_hi = (pos_q < thresh_q);

endmodule

// File: rtl/ctl_duty_calc.sv
// Module: turns a pulse kind and a measured period length into a high time.
// Plain pulses scale by the duty register; 1, 0 and mark pulses use fixed
// quarter, half and three-quarter fractions. Purely combinational.
module ctl_duty_calc
    import ctl_mark_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DUTY_W = 8
) (
    input  pulse_kind_e       kind,
    input  logic [CNT_W-1:0]  len,
    input  logic [DUTY_W-1:0] duty,
    output logic [CNT_W-1:0]  thresh
);

    localparam int PROD_W = CNT_W + DUTY_W;

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  quarter;

    assign prod    = PROD_W'(len) * PROD_W'(duty);
    assign quarter = len >> 2;

    // Select the high time for the requested pulse kind.
    always_comb begin
        unique case (kind)
            PK_ONE:  thresh = quarter;
            PK_ZERO: thresh = len >> 1;
            PK_MARK: thresh = len - quarter;
            default: thresh = CNT_W'(prod >> DUTY_W);
        endcase
    end

endmodule

// File: rtl/ctl_frame_seq.sv
// Module: decides the kind of each pulse. Runs the framed index word
// (0, data x FRAME_BITS, 0), buffers the software flag, tracks underrun,
// handles abort and address-mark requests, and raises the interrupt.
// Assumes flag writes and mode are synchronous to clk.
module ctl_frame_seq
    import ctl_mark_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boundary,
    input  rec_mode_e   mode,
    input  logic        flag_wr,
    input  logic        flag_val,
    output pulse_kind_e kind,
    output logic        irq,
    output logic        bit_pending,
    output logic        underrun,
    output logic        active
);

    localparam int IDX_W = $clog2(FRAME_BITS + 3);
    localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(FRAME_BITS + 2);

    logic [IDX_W-1:0] idx_q;
    logic             armed_q;
    logic             pend_q;
    logic             pend_val_q;
    logic             last_bit_q;
    logic             mark_pend_q;

    logic is_idx_mode;
    logic do_start;
    logic do_abort;
    logic do_done;
    logic do_data;
    logic data_bit;

    assign is_idx_mode = (mode == MODE_INDEX) || (mode == MODE_REWRITE);
    assign do_abort    = boundary && active && (mode == MODE_ABORT);
    assign do_done     = boundary && active && !do_abort && (idx_q == IDX_DONE);
    assign do_data     = boundary && active && !do_abort
                         && (idx_q != IDX_DONE) && (idx_q != IDX_TAIL);
    assign do_start    = boundary && !active && armed_q && is_idx_mode;
    assign data_bit    = pend_q ? pend_val_q : last_bit_q;

    // Pulse kind for the boundary in this cycle.
    always_comb begin
        kind = PK_PLAIN;
        if (active) begin
            if (do_data) begin
                kind = data_bit ? PK_ONE : PK_ZERO;
            end else if (!do_abort && (idx_q == IDX_TAIL)) begin
                kind = PK_ZERO;
            end
        end else if (armed_q && is_idx_mode) begin
            kind = PK_ZERO;
        end else if ((mode == MODE_MARK) && mark_pend_q) begin
            kind = PK_MARK;
        end
    end

    // Frame state: active flag, pulse index and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            if (do_start) begin
                active  <= 1'b1;
                idx_q   <= IDX_W'(1);
                armed_q <= 1'b0;
            end else if (do_abort || do_done) begin
                active <= 1'b0;
            end else if (boundary && active) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (!active && !is_idx_mode) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Data flag buffer, repeated-bit memory and sticky underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
            last_bit_q <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            if (do_start) begin
                last_bit_q <= 1'b0;
                underrun   <= 1'b0;
            end
            if (do_data) begin
                last_bit_q <= data_bit;
                pend_q     <= 1'b0;
                if (!pend_q) begin
                    underrun <= 1'b1;
                end
            end
            if (flag_wr && (mode != MODE_MARK)) begin
                pend_q     <= 1'b1;
                pend_val_q <= flag_val;
            end
        end
    end

    // Address-mark request: set by a 0 write in mark mode, used at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_pend_q <= 1'b0;
        end else begin
            if (boundary && (kind == PK_MARK)) begin
                mark_pend_q <= 1'b0;
            end
            if (flag_wr && !flag_val && (mode == MODE_MARK)) begin
                mark_pend_q <= 1'b1;
            end
        end
    end

    // Interrupt: frame completion, or every boundary in mark mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= do_done || (boundary && !active && (mode == MODE_MARK));
        end
    end

    assign bit_pending = pend_q;

endmodule

// File: rtl/ctl_mark_rec.sv
// Module: top of the control-pulse mark recorder. Ties the frame sequencer,
// the duty calculator and the period timer together. Assumes period_tick,
// mode_sel, duty_val and flag writes are all synchronous to clk.
module ctl_mark_rec
    import ctl_mark_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int DUTY_W     = 8,
    parameter int FRAME_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_tick,
    input  logic [2:0]        mode_sel,
    input  logic [DUTY_W-1:0] duty_val,
    input  logic              flag_wr,
    input  logic              flag_val,
    output logic              rec_pulse,
    output logic              irq,
    output logic              bit_pending,
    output logic              underrun
);

    pulse_kind_e      kind;
    logic [CNT_W-1:0] len_now;
    logic [CNT_W-1:0] thresh_next;
    logic             seq_active;

    ctl_frame_seq #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (period_tick),
        .mode        (rec_mode_e'(mode_sel)),
        .flag_wr     (flag_wr),
        .flag_val    (flag_val),
        .kind        (kind),
        .irq         (irq),
        .bit_pending (bit_pending),
        .underrun    (underrun),
        .active      (seq_active)
    );

    ctl_duty_calc #(
        .CNT_W  (CNT_W),
        .DUTY_W (DUTY_W)
    ) u_duty (
        .kind   (kind),
        .len    (len_now),
        .duty   (duty_val),
        .thresh (thresh_next)
    );

    ctl_period_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (period_tick),
        .thresh_next (thresh_next),
        .len_now     (len_now),
        .pulse_hi    (rec_pulse)
    );

endmodule

// File: rtl/ctl_mark_rec_checker.sv
// Module: protocol checks for the control-pulse mark recorder, bound to the top.
module ctl_mark_rec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       period_tick,
    input logic [2:0] mode_sel,
    input logic       rec_pulse,
    input logic       irq,
    input logic       bit_pending,
    input logic       underrun,
    input logic       frame_active
);

    // A pulse can only begin right after a boundary edge.
    assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_pulse) |-> $past(period_tick));

    // A pending bit is consumed only at a boundary.
    assert_pending_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bit_pending) |-> $past(period_tick));

    // Underrun is raised only at a boundary.
    assert_underrun_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(period_tick));

    // Any interrupt follows a boundary.
    assert_irq_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(period_tick));

    // Abort code at a boundary never yields an interrupt.
    assert_abort_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && (mode_sel == 3'd3)) |=> !irq);

    // Mark mode interrupts at every boundary outside a frame.
    assert_mark_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && (mode_sel == 3'd4) && !frame_active) |=> irq);

endmodule

bind ctl_mark_rec ctl_mark_rec_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_tick  (period_tick),
    .mode_sel     (mode_sel),
    .rec_pulse    (rec_pulse),
    .irq          (irq),
    .bit_pending  (bit_pending),
    .underrun     (underrun),
    .frame_active (seq_active)
);

// File: tb/ctl_mark_rec_bench.sv
// Bench: a vector table for plain and mark pulses, then directed frame,
// underrun, abort and reset tests. The period is 40 clocks.
module ctl_mark_rec_bench;

    localparam int P = 40;

    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] duty;
        logic       wr;
        logic       val;
        logic [7:0] hi;
        logic       irq;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 8'd64,  1'b0, 1'b0, 8'd10, 1'b0},
        '{3'd0, 8'd128, 1'b0, 1'b0, 8'd20, 1'b0},
        '{3'd0, 8'd0,   1'b0, 1'b0, 8'd0,  1'b0},
        '{3'd0, 8'd255, 1'b0, 1'b0, 8'd39, 1'b0},
        '{3'd4, 8'd128, 1'b1, 1'b0, 8'd20, 1'b1},
        '{3'd4, 8'd128, 1'b0, 1'b0, 8'd30, 1'b1},
        '{3'd4, 8'd128, 1'b1, 1'b1, 8'd20, 1'b1},
        '{3'd4, 8'd128, 1'b0, 1'b0, 8'd20, 1'b1},
        '{3'd0, 8'd200, 1'b0, 1'b0, 8'd31, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_tick = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic [7:0] duty_val = 8'd0;
    logic       flag_wr = 1'b0;
    logic       flag_val = 1'b0;
    logic       rec_pulse, irq, bit_pending, underrun;

    int  n_checks = 0;
    int  n_fail = 0;
    int  tcnt = 0;
    bit  tick_en = 1'b0;
    bit  done = 1'b0;
    int  last_hi;
    bit  last_irq, last_pend, last_under;

    ctl_mark_rec u_ctl_mark_rec (
        .clk (clk), .rst_n (rst_n), .period_tick (period_tick),
        .mode_sel (mode_sel), .duty_val (duty_val), .flag_wr (flag_wr),
        .flag_val (flag_val), .rec_pulse (rec_pulse), .irq (irq),
        .bit_pending (bit_pending), .underrun (underrun)
    );

    always #10 clk = ~clk;

    // Period tick generator: one strobe every P clocks.
    always @(negedge clk) begin
        if (!tick_en) begin
            tcnt = 0;
            period_tick = 1'b0;
        end else begin
            tcnt = (tcnt == P - 1) ? 0 : tcnt + 1;
            period_tick = (tcnt == P - 1);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for a boundary edge, then record one whole pulse; optionally write the flag.
    task automatic run_pulse(input bit wr_en, input bit wr_val);
        forever begin
            @(posedge clk);
            if (period_tick) break;
        end
        last_hi = 0;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            if (rec_pulse) last_hi++;
            if (c == 0) begin
                last_irq = irq;
                if (wr_en) begin
                    flag_wr  = 1'b1;
                    flag_val = wr_val;
                end
            end
            if (c == 1) flag_wr = 1'b0;
            if (c == P - 1) begin
                last_pend  = bit_pending;
                last_under = underrun;
            end
        end
    endtask

    function automatic bit pat(input int i);
        return (i % 3) != 0;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        check("R11 rec_pulse", rec_pulse, 0);
        check("R11 irq", irq, 0);
        check("R11 bit_pending", bit_pending, 0);
        check("R11 underrun", underrun, 0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        run_pulse(1'b0, 1'b0);
        run_pulse(1'b0, 1'b0);

        // Table: plain duty (R2) and address-mark behaviour (R9, R10).
        for (int v = 0; v < 9; v++) begin
            mode_sel = VECS[v].mode;
            duty_val = VECS[v].duty;
            run_pulse(VECS[v].wr, VECS[v].val);
            check((VECS[v].mode == 3'd4) ? "R9 mark high time" : "R2 plain high time",
                  last_hi, int'(VECS[v].hi));
            check((VECS[v].mode == 3'd4) ? "R10 mark irq" : "R2 no irq",
                  last_irq, int'(VECS[v].irq));
        end

        // Index frame (R3, R4, R6).
        mode_sel = 3'd0; duty_val = 8'd64;
        run_pulse(1'b0, 1'b0);
        mode_sel = 3'd1;
        run_pulse(1'b1, pat(1));
        check("R3 leading zero", last_hi, 20);
        check("R4 bit pending after write", last_pend, 1);
        begin
            int bad = 0;
            int irqs = 0;
            for (int i = 1; i <= 64; i++) begin
                run_pulse(i < 64, pat(i + 1));
                if (last_hi != (pat(i) ? 10 : 20)) bad++;
                if (last_irq) irqs++;
            end
            check("R3 data pulse mismatches", bad, 0);
            check("R6 no irq inside frame", irqs, 0);
        end
        check("R4 pending consumed", last_pend, 0);
        duty_val = 8'd0;
        run_pulse(1'b0, 1'b0);
        check("R3 trailing zero", last_hi, 20);
        run_pulse(1'b0, 1'b0);
        check("R6 completion irq", last_irq, 1);
        check("R6 plain duty after frame", last_hi, 0);
        check("R5 no underrun on full frame", last_under, 0);
        run_pulse(1'b0, 1'b0);
        check("R6 no restart without re-arm", last_hi, 0);
        check("R6 single irq", last_irq, 0);

        // Rewrite mode with underrun (R7, R5), then abort (R8).
        mode_sel = 3'd0;
        run_pulse(1'b0, 1'b0);
        mode_sel = 3'd2;
        run_pulse(1'b1, 1'b1);
        check("R7 rewrite leading zero", last_hi, 20);
        run_pulse(1'b0, 1'b0);
        check("R7 rewrite data one", last_hi, 10);
        check("R5 no underrun yet", last_under, 0);
        run_pulse(1'b0, 1'b0);
        check("R5 repeated bit", last_hi, 10);
        check("R5 underrun set", last_under, 1);
        mode_sel = 3'd3;
        run_pulse(1'b0, 1'b0);
        check("R8 abort plain duty", last_hi, 0);
        check("R8 abort no irq", last_irq, 0);
        begin
            int irqs = 0;
            for (int i = 0; i < 70; i++) begin
                run_pulse(1'b0, 1'b0);
                if (last_irq) irqs++;
            end
            check("R8 no completion irq after abort", irqs, 0);
        end

        // Reset corner: reset mid-frame clears the outputs (R11).
        mode_sel = 3'd1;
        run_pulse(1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 pending cleared by reset", bit_pending, 0);
        check("R11 output low in reset", rec_pulse, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule